// File: doc/BRIEF.md
# Standby-Isolating General-Purpose I/O Port

This block is an 8-bit general-purpose I/O port. It sits between a simple CPU register bus and the per-pin pad controls. Four per-pin registers set its behaviour: output data, direction, pull-up enable and digital-select. The port builds the pad output enable, output level, pull-up request and input-buffer enable from these registers. A peripheral that asserts its own per-pin output enable takes over that pin's drive. Pad inputs pass through a two-flop synchronizer. The synchronized values then reach the CPU, the peripherals and the external-interrupt logic.

When the device is in a low-power standby state and the isolation control bit is set, the port forces every pad to high impedance and drops all pull-ups. It also blocks each input buffer and holds that pin's internal value low, so a floating pad cannot leak. A pin whose external interrupt is enabled is exempt from the input blocking, so it can still wake the device. When the isolation bit is clear, the port holds the pads at the drive state they had on entry for the whole standby period.

Top module: `gpio_sb_port`

## Requirements
- R1: After reset, every register reads 0. `pad_oe`, `pad_pu` and `pad_out` are all 0, and `pad_ie` equals `irq_en`. Every pin starts as an analog input with no pull-up.
- R2: A write with `bus_we`=1 loads `bus_wdata` into the register chosen by `bus_addr`: 0 = data, 1 = direction (1 = output), 2 = pull-up enable, 3 = digital-select (0 = analog). `bus_rdata` returns the direction, pull-up and digital-select registers unchanged at addresses 1, 2 and 3.
- R3: Outside standby, a pin whose peripheral override is off drives `pad_oe` = direction bit and `pad_out` = data bit.
- R4: Outside standby, a pin whose `per_oe` bit is 1 drives `pad_oe`=1 and `pad_out`=`per_do`, whatever its registers hold.
- R5: At address 0, `bus_rdata` gives the data register bit for output pins. For input pins it gives `pin_in`, which is the pad value after two rising clock edges of synchronization, gated as in R6, R9 and R10.
- R6: A pin is analog when its direction bit is 0 and its digital-select bit is 0. Outside standby, an analog pin has `pin_in`=0, and its `pad_ie` is 0 unless its `irq_en` bit is 1.
- R7: Outside standby, `extint_in` carries the synchronized pad value of every pin whose input buffer is on. The buffer is on for every digital pin and for every pin with `irq_en`=1, even in analog mode. `extint_in` is 0 on all other pins.
- R8: Isolation is `stby_req`=1 together with `stby_iso`=1. During isolation, `pad_oe`, `pad_out` and `pad_pu` are 0 on every pin, whatever the registers and the peripheral overrides hold.
- R9: During isolation, a pin with `irq_en`=0 has `pad_ie`=0, `pin_in`=0 and `extint_in`=0. Its data read returns 0 unless it is an output pin.
- R10: During isolation, a pin with `irq_en`=1 keeps `pad_ie`=1, and both `pin_in` and `extint_in` follow its synchronized pad value.
- R11: While `stby_req`=1 and `stby_iso`=0, `pad_oe` and `pad_out` keep the values they had in the last cycle before standby. Changes to the registers or the peripheral overrides during that time have no effect on them. The new values take effect once `stby_req` falls.
- R12: `pad_pu` is 1 only when the pin's pull-up bit is 1, its `pad_oe` is 0, the pin is digital and isolation is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data (combinational from `bus_addr`) |
| stby_req | input | 1 | Device is in a standby state |
| stby_iso | input | 1 | Isolate pads while in standby |
| irq_en | input | 8 | Per-pin external interrupt enable |
| per_oe | input | 8 | Per-pin peripheral output override |
| per_do | input | 8 | Per-pin peripheral output data |
| pad_in | input | 8 | Raw pad input levels |
| pad_oe | output | 8 | Pad output enable |
| pad_out | output | 8 | Pad output level |
| pad_pu | output | 8 | Pad pull-up request |
| pad_ie | output | 8 | Pad input-buffer enable |
| pin_in | output | 8 | Gated, synchronized pin value for CPU and peripherals |
| extint_in | output | 8 | Synchronized pin value for the external-interrupt logic |

## Verification
Isolation and peripheral override can land on the same pin in the same cycle, and isolation has to win. The same applies to isolation and the interrupt exemption on a pin that is also in analog mode. The bench provokes these cases by sweeping all 256 per-pin combinations of direction, digital-select, pull-up, data, override, override data, interrupt enable and pad level. Each combination is run once with isolation off and once with isolation on. It judges every output bit against an expression it builds from the requirements. A separate sequence enters standby with isolation off, changes the overrides and the registers, then switches isolation on and off. It checks that the held drive survives each step and is released only when standby ends.

// File: rtl/gpio_sb_pkg.sv
package gpio_sb_pkg;
   typedef enum logic [1:0] {
      RA_DATA = 2'd0,
      RA_DIR  = 2'd1,
      RA_PULL = 2'd2,
      RA_DSEL = 2'd3
   } reg_addr_e;
endpackage

// File: rtl/gpio_sb_regs.sv
module gpio_sb_regs #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [1:0]       addr,
   input  logic [WIDTH-1:0] wdata,
   output logic [WIDTH-1:0] data_q,
   output logic [WIDTH-1:0] dir_q,
   output logic [WIDTH-1:0] pull_q,
   output logic [WIDTH-1:0] dsel_q
);
   import gpio_sb_pkg::*;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q <= '0;
         dir_q  <= '0;
         pull_q <= '0;
         dsel_q <= '0;
      end else if (we) begin
         case (reg_addr_e'(addr))
            RA_DATA: data_q <= wdata;
            RA_DIR:  dir_q  <= wdata;
            RA_PULL: pull_q <= wdata;
            default: dsel_q <= wdata;
         endcase
      end
   end
endmodule

// File: rtl/gpio_sb_sync.sv
module gpio_sb_sync #(
   parameter int WIDTH  = 8,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [STAGES-1:0][WIDTH-1:0] stage_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage_q <= '0;
      end else begin
         stage_q[0] <= d;
         for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
      end
   end

   assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_sb_pinctl.sv
module gpio_sb_pinctl #(
   parameter int WIDTH        = 8,
   parameter bit HOLD_IN_STBY = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             stby_req,
   input  logic             stby_iso,
   input  logic [WIDTH-1:0] data_q,
   input  logic [WIDTH-1:0] dir_q,
   input  logic [WIDTH-1:0] pull_q,
   input  logic [WIDTH-1:0] dsel_q,
   input  logic [WIDTH-1:0] irq_en,
   input  logic [WIDTH-1:0] per_oe,
   input  logic [WIDTH-1:0] per_do,
   input  logic [WIDTH-1:0] sync_q,
   output logic [WIDTH-1:0] pad_oe,
   output logic [WIDTH-1:0] pad_out,
   output logic [WIDTH-1:0] pad_pu,
   output logic [WIDTH-1:0] pad_ie,
   output logic [WIDTH-1:0] pin_in,
   output logic [WIDTH-1:0] extint_in
);
   logic             isolate;
   logic [WIDTH-1:0] eff_oe, eff_do;
   logic [WIDTH-1:0] live_oe, live_do;

   assign isolate = stby_req & stby_iso;

   // Standby-without-isolation variant: keep the drive state from entry.
   generate
      if (HOLD_IN_STBY) begin : g_hold
         logic [WIDTH-1:0] hold_oe, hold_do;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               hold_oe <= '0;
               hold_do <= '0;
            end else if (!stby_req) begin
               hold_oe <= eff_oe;
               hold_do <= eff_do;
            end
         end
         assign live_oe = stby_req ? hold_oe : eff_oe;
         assign live_do = stby_req ? hold_do : eff_do;
      end else begin : g_pass
         assign live_oe = eff_oe;
         assign live_do = eff_do;
      end
   endgenerate

   generate
      for (genvar i = 0; i < WIDTH; i++) begin : g_pin
         logic digital;
         logic dig_en;
         assign digital      = dir_q[i] | dsel_q[i];
         assign eff_oe[i]    = per_oe[i] | dir_q[i];
         assign eff_do[i]    = per_oe[i] ? per_do[i] : data_q[i];
         assign pad_oe[i]    = ~isolate & live_oe[i];
         assign pad_out[i]   = ~isolate & live_do[i];
         assign pad_pu[i]    = pull_q[i] & ~pad_oe[i] & digital & ~isolate;
         assign pad_ie[i]    = isolate ? irq_en[i] : (digital | irq_en[i]);
         assign dig_en       = isolate ? irq_en[i] : digital;
         assign pin_in[i]    = sync_q[i] & dig_en;
         assign extint_in[i] = sync_q[i] & pad_ie[i];
      end
   endgenerate
endmodule

// File: rtl/gpio_sb_port.sv
module gpio_sb_port #(
   parameter int WIDTH        = 8,
   parameter int SYNC_STAGES  = 2,
   parameter bit HOLD_IN_STBY = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_we,
   input  logic [1:0]       bus_addr,
   input  logic [WIDTH-1:0] bus_wdata,
   output logic [WIDTH-1:0] bus_rdata,
   input  logic             stby_req,
   input  logic             stby_iso,
   input  logic [WIDTH-1:0] irq_en,
   input  logic [WIDTH-1:0] per_oe,
   input  logic [WIDTH-1:0] per_do,
   input  logic [WIDTH-1:0] pad_in,
   output logic [WIDTH-1:0] pad_oe,
   output logic [WIDTH-1:0] pad_out,
   output logic [WIDTH-1:0] pad_pu,
   output logic [WIDTH-1:0] pad_ie,
   output logic [WIDTH-1:0] pin_in,
   output logic [WIDTH-1:0] extint_in
);
   import gpio_sb_pkg::*;

   generate
      if (WIDTH < 1 || WIDTH > 32) begin : g_bad_width
         $error("gpio_sb_port: WIDTH must lie in 1..32");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("gpio_sb_port: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] data_q, dir_q, pull_q, dsel_q, sync_q;

   gpio_sb_regs #(.WIDTH(WIDTH)) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (bus_we),
      .addr   (bus_addr),
      .wdata  (bus_wdata),
      .data_q (data_q),
      .dir_q  (dir_q),
      .pull_q (pull_q),
      .dsel_q (dsel_q)
   );

   gpio_sb_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pad_in),
      .q     (sync_q)
   );

   gpio_sb_pinctl #(.WIDTH(WIDTH), .HOLD_IN_STBY(HOLD_IN_STBY)) u_pins (
      .clk       (clk),
      .rst_n     (rst_n),
      .stby_req  (stby_req),
      .stby_iso  (stby_iso),
      .data_q    (data_q),
      .dir_q     (dir_q),
      .pull_q    (pull_q),
      .dsel_q    (dsel_q),
      .irq_en    (irq_en),
      .per_oe    (per_oe),
      .per_do    (per_do),
      .sync_q    (sync_q),
      .pad_oe    (pad_oe),
      .pad_out   (pad_out),
      .pad_pu    (pad_pu),
      .pad_ie    (pad_ie),
      .pin_in    (pin_in),
      .extint_in (extint_in)
   );

   always_comb begin
      case (reg_addr_e'(bus_addr))
         RA_DATA: bus_rdata = (dir_q & data_q) | (~dir_q & pin_in);
         RA_DIR:  bus_rdata = dir_q;
         RA_PULL: bus_rdata = pull_q;
         default: bus_rdata = dsel_q;
      endcase
   end
endmodule

// File: rtl/gpio_sb_chk.sv
module gpio_sb_chk #(
   parameter int WIDTH        = 8,
   parameter bit HOLD_IN_STBY = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             stby_req,
   input logic             stby_iso,
   input logic [WIDTH-1:0] irq_en,
   input logic [WIDTH-1:0] per_oe,
   input logic [WIDTH-1:0] per_do,
   input logic [WIDTH-1:0] pad_oe,
   input logic [WIDTH-1:0] pad_out,
   input logic [WIDTH-1:0] pad_pu,
   input logic [WIDTH-1:0] pad_ie,
   input logic [WIDTH-1:0] pin_in,
   input logic [WIDTH-1:0] extint_in
);
   logic iso;
   assign iso = stby_req & stby_iso;

   // R8: isolation releases every pad and every pull-up
   a_r8_iso_hiz: assert property (@(posedge clk) disable iff (!rst_n)
      iso |-> (pad_oe == '0 && pad_out == '0 && pad_pu == '0));

   // R9: blocked inputs read low on pins without an interrupt
   a_r9_clamp_low: assert property (@(posedge clk) disable iff (!rst_n)
      iso |-> (((pin_in | extint_in | pad_ie) & ~irq_en) == '0));

   // R10: interrupt pins keep their input buffer in isolation
   a_r10_irq_live: assert property (@(posedge clk) disable iff (!rst_n)
      iso |-> ((pad_ie & irq_en) == irq_en && (pin_in & irq_en) == (extint_in & irq_en)));

   // R4: peripheral override owns the pin outside standby
   a_r4_override: assert property (@(posedge clk) disable iff (!rst_n)
      !stby_req |-> ((pad_oe & per_oe) == per_oe && (pad_out & per_oe) == (per_do & per_oe)));

   // R12: no pull-up on a driven pin
   a_r12_pu_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      (pad_pu & pad_oe) == '0);

   // R11: drive frozen through non-isolating standby
   generate
      if (HOLD_IN_STBY) begin : g_hold_chk
         a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (stby_req && !stby_iso && $past(stby_req && !stby_iso))
               |-> ($stable(pad_oe) && $stable(pad_out)));
      end
   endgenerate
endmodule

bind gpio_sb_port gpio_sb_chk #(.WIDTH(WIDTH), .HOLD_IN_STBY(HOLD_IN_STBY)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .stby_req  (stby_req),
   .stby_iso  (stby_iso),
   .irq_en    (irq_en),
   .per_oe    (per_oe),
   .per_do    (per_do),
   .pad_oe    (pad_oe),
   .pad_out   (pad_out),
   .pad_pu    (pad_pu),
   .pad_ie    (pad_ie),
   .pin_in    (pin_in),
   .extint_in (extint_in)
);

// File: tb/sim_gpio_sb_port.sv
`timescale 1ns/1ps
module sim_gpio_sb_port;
   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         bus_we = 1'b0;
   logic [1:0]   bus_addr = 2'd0;
   logic [W-1:0] bus_wdata = '0;
   logic [W-1:0] bus_rdata;
   logic         stby_req = 1'b0;
   logic         stby_iso = 1'b0;
   logic [W-1:0] irq_en = '0, per_oe = '0, per_do = '0, pad_in = '0;
   logic [W-1:0] pad_oe, pad_out, pad_pu, pad_ie, pin_in, extint_in;

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   gpio_sb_port #(.WIDTH(W)) u0 (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .stby_req(stby_req),
      .stby_iso(stby_iso), .irq_en(irq_en), .per_oe(per_oe), .per_do(per_do),
      .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu),
      .pad_ie(pad_ie), .pin_in(pin_in), .extint_in(extint_in)
   );

   task automatic chk(input string rq, input string nm, input logic [W-1:0] act,
                      input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%h expected=%h", rq, nm, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [W-1:0] v);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = a; bus_wdata = v;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [W-1:0] v);
      @(negedge clk);
      bus_addr = a;
      #0.5 v = bus_rdata;
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   initial begin
      #(4.0 * 200000);
      failures++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      logic [W-1:0] v;
      logic [W-1:0] e_oe, e_out, e_pu, e_ie, e_pin, e_ext, e_rd;
      logic [W-1:0] dir, dsel, pull, data;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      @(negedge clk);
      chk("R1", "pad_oe", pad_oe, '0);
      chk("R1", "pad_out", pad_out, '0);
      chk("R1", "pad_pu", pad_pu, '0);
      chk("R1", "pad_ie", pad_ie, '0);
      for (int a = 0; a < 4; a++) begin
         rd(a[1:0], v);
         chk("R1", "reg", v, '0);
      end

      // R2 write/read of configuration registers
      wr(2'd1, 8'h5A); wr(2'd2, 8'hC3); wr(2'd3, 8'h96);
      rd(2'd1, v); chk("R2", "dir", v, 8'h5A);
      rd(2'd2, v); chk("R2", "pull", v, 8'hC3);
      rd(2'd3, v); chk("R2", "dsel", v, 8'h96);

      // Exhaustive per-pin sweep: combination index = iter*8 + pin
      for (int iso = 0; iso < 2; iso++) begin
         for (int it = 0; it < 32; it++) begin
            for (int b = 0; b < W; b++) begin
               int c;
               c = it * 8 + b;
               dir[b]    = c[0]; dsel[b]   = c[1]; pull[b] = c[2]; data[b] = c[3];
               per_oe[b] = c[4]; per_do[b] = c[5]; irq_en[b] = c[6]; pad_in[b] = c[7];
            end
            stby_req = 1'b0; stby_iso = 1'b0;
            wr(2'd0, data); wr(2'd1, dir); wr(2'd2, pull); wr(2'd3, dsel);
            stby_req = (iso == 1); stby_iso = (iso == 1);
            repeat (3) @(negedge clk);
            for (int b = 0; b < W; b++) begin
               logic dg, oe, dq;
               dg = dir[b] | dsel[b];
               oe = per_oe[b] | dir[b];
               dq = per_oe[b] ? per_do[b] : data[b];
               if (iso == 1) begin
                  e_oe[b] = 1'b0; e_out[b] = 1'b0; e_pu[b] = 1'b0;
                  e_ie[b] = irq_en[b];
                  e_pin[b] = pad_in[b] & irq_en[b];
                  e_ext[b] = pad_in[b] & irq_en[b];
               end else begin
                  e_oe[b] = oe; e_out[b] = dq;
                  e_pu[b] = pull[b] & ~oe & dg;
                  e_ie[b] = dg | irq_en[b];
                  e_pin[b] = pad_in[b] & dg;
                  e_ext[b] = pad_in[b] & (dg | irq_en[b]);
               end
               e_rd[b] = dir[b] ? data[b] : e_pin[b];
            end
            if (iso == 1) begin
               chk("R8", "pad_oe", pad_oe, e_oe);
               chk("R8", "pad_out", pad_out, e_out);
               chk("R8", "pad_pu", pad_pu, e_pu);
               chk("R9", "pad_ie", pad_ie, e_ie);
               chk("R10", "pin_in", pin_in, e_pin);
               chk("R10", "extint_in", extint_in, e_ext);
               rd(2'd0, v); chk("R9", "data_read", v, e_rd);
            end else begin
               chk("R3_R4", "pad_oe", pad_oe, e_oe);
               chk("R3_R4", "pad_out", pad_out, e_out);
               chk("R12", "pad_pu", pad_pu, e_pu);
               chk("R6", "pad_ie", pad_ie, e_ie);
               chk("R6", "pin_in", pin_in, e_pin);
               chk("R7", "extint_in", extint_in, e_ext);
               rd(2'd0, v); chk("R5", "data_read", v, e_rd);
            end
         end
      end

      // R11 hold through non-isolating standby
      stby_req = 1'b0; stby_iso = 1'b0; irq_en = '0;
      wr(2'd1, 8'hF0); wr(2'd0, 8'hA5);
      @(negedge clk); per_oe = 8'h03; per_do = 8'h02;
      @(negedge clk);
      chk("R4", "pad_oe", pad_oe, 8'hF3);
      chk("R4", "pad_out", pad_out, 8'hA6);
      stby_req = 1'b1;
      @(negedge clk); per_oe = '0; per_do = '0;
      wr(2'd0, 8'h3C);
      @(negedge clk);
      chk("R11", "pad_oe_held", pad_oe, 8'hF3);
      chk("R11", "pad_out_held", pad_out, 8'hA6);
      stby_iso = 1'b1;
      @(negedge clk);
      chk("R8", "pad_oe_iso", pad_oe, 8'h00);
      stby_iso = 1'b0;
      @(negedge clk);
      chk("R11", "pad_oe_reheld", pad_oe, 8'hF3);
      chk("R11", "pad_out_reheld", pad_out, 8'hA6);
      stby_req = 1'b0;
      @(negedge clk);
      chk("R11", "pad_oe_release", pad_oe, 8'hF0);
      chk("R11", "pad_out_release", pad_out, 8'h3C);

      finish_run();
   end
endmodule